// File: doc/BRIEF.md
# Dual-Compare Interval Timer

This block is a peripheral timer: a free-running 10-bit up-counter and two compare channels, each with its own match value. Software reaches it through a byte-wide port with two register addresses. The first is a control/status register. Its read side and its write side hold different things. A read returns the sticky match flags of both channels together with the run bit, and the read clears those flags as a side effect. A write programs the two interrupt enables and the run bit. The second address is a control register. It picks the count source and a 2-bit interrupt priority.

The counter advances on single-cycle count-enable pulses in the one system clock domain. The pulse source is one of three. The first is a base rate of one pulse every 2 system clocks. The second is that base rate divided by a further 8. The third is a tick input driven by an external cascade timer. The two match values are loaded through a separate compare-load port.

The interrupt request combines every flag that has its enable set. The request is driven only when the priority field is nonzero, and the priority goes out beside it.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the counter, both match values, both flags, both enables, the run bit, the source field and the priority field are zero, and `irq` is low.
- R2: A read of address 0 returns bits 7:3 as zero, bit 2 as the channel-2 flag, bit 1 as the channel-1 flag and bit 0 as the run bit.
- R3: A read of address 0 clears both flags, and so any request they caused. It leaves both interrupt enables unchanged.
- R4: If a channel matches in the same cycle as a read of address 0, that channel's flag is set after the read.
- R5: A write to address 0 loads the channel-2 enable from bit 2, the channel-1 enable from bit 1 and the run bit from bit 0. While the run bit is 0 the counter holds its value.
- R6: With source field 00 (control bits 3:2), the counter advances exactly once every 2 clocks.
- R7: With source field 10 or 11, the counter advances exactly once every 16 clocks.
- R8: With source field 01, the counter advances once for each clock in which `cascade_tick` is high, and at no other time.
- R9: Control register bits 7:4 ignore writes and read as zero. Bits 3:2 (source) and 1:0 (priority) read back as written.
- R10: A channel sets its flag on a count-enable cycle in which the counter equals its match value. The counter wraps from 1023 to 0.
- R11: `irq` is high exactly when some flag is set together with its enable and the priority field is nonzero. `irq_pri` always equals the priority field.
- R12: A pulse on `cmp_we` loads `cmp_val` into the channel-2 match value when `cmp_sel` is 1, and into the channel-1 match value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Register access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 1 | 0 = control/status, 1 = control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the access cycle |
| cmp_we | input | 1 | Match value load strobe |
| cmp_sel | input | 1 | 0 = channel 1, 1 = channel 2 |
| cmp_val | input | 10 | Match value to load |
| cascade_tick | input | 1 | Count pulse from the cascade timer |
| cnt_out | output | 10 | Current counter value |
| irq | output | 1 | Interrupt request |
| irq_pri | output | 2 | Priority of the request |

## Verification
A wrong prescaler phase shows up at once on `cnt_out`: the count drifts from the 2-clock, 16-clock or per-tick schedule within one pulse period. A flag that sets one pulse late, or that the clearing read wrongly erases, shows on the next status read and on `irq` within a clock. An enable that the clearing read disturbs stays hidden until the next match, when `irq` fails to rise, so that case is checked over a full counter wrap.

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int CW       = 10,
  parameter int SLOW_DIV = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic          addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          cmp_we,
  input  logic          cmp_sel,
  input  logic [CW-1:0] cmp_val,
  input  logic          cascade_tick,
  output logic [CW-1:0] cnt_out,
  output logic          irq,
  output logic [1:0]    irq_pri
);
  localparam int DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DW-1:0] DLAST = DW'(SLOW_DIV - 1);

  logic          run, ph;
  logic [2:1]    ien, flg;
  logic [1:0]    src, pri;
  logic [CW-1:0] cnt, m1, m2;
  logic [DW-1:0] dv;
  logic          tick;

  wire wr_csr = cs & we & ~addr;
  wire wr_cr  = cs & we & addr;
  wire rd_csr = cs & ~we & ~addr;
  wire base   = run & ph;

  always_comb begin
    case (src)
      2'b00:   tick = base;
      2'b01:   tick = run & cascade_tick;
      default: tick = base & (dv == DLAST);
    endcase
  end

  wire [2:1] hit = {tick & (cnt == m2), tick & (cnt == m1)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      ph  <= 1'b0;
      dv  <= '0;
      cnt <= '0;
      m1  <= '0;
      m2  <= '0;
      ien <= '0;
      flg <= '0;
      src <= '0;
      pri <= '0;
    end else begin
      if (run) ph <= ~ph;
      if (base) dv <= (dv == DLAST) ? '0 : dv + 1'b1;
      if (tick) cnt <= cnt + 1'b1;
      if (wr_csr) begin
        ien <= wdata[2:1];
        run <= wdata[0];
      end
      if (wr_cr) begin
        src <= wdata[3:2];
        pri <= wdata[1:0];
      end
      if (cmp_we) begin
        if (cmp_sel) m2 <= cmp_val;
        else         m1 <= cmp_val;
      end
      flg <= (rd_csr ? 2'b00 : flg) | hit;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (cs && !we) rdata = addr ? {4'b0, src, pri} : {5'b0, flg, run};
  end

  assign cnt_out = cnt;
  assign irq     = (|(flg & ien)) && (pri != 2'b00);
  assign irq_pri = pri;

  // R5
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_out));

  // R11
  no_irq_pri0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pri == 2'b00) |-> !irq);

  // R3
  enables_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_csr && !wr_csr) |=> $stable(ien));

  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_csr && hit == 2'b00) |=> (flg == 2'b00));

  // R4
  match_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_csr && hit[1]) |=> flg[1]);

  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_out == '1) |=> (cnt_out == '0));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && !addr) |-> (rdata[7:3] == 5'b0));
endmodule

// File: tb/sim_dual_cmp_timer.sv
module sim_dual_cmp_timer;
  logic       clk = 0, rst_n = 0, cs = 0, we = 0, addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       cmp_we = 0, cmp_sel = 0, cascade_tick = 0;
  logic [9:0] cmp_val = 0, cnt_out;
  logic       irq;
  logic [1:0] irq_pri;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_cmp_timer u0 (.clk, .rst_n, .cs, .we, .addr, .wdata, .rdata, .cmp_we,
    .cmp_sel, .cmp_val, .cascade_tick, .cnt_out, .irq, .irq_pri);

  localparam logic [15:0] CRV [6] = '{16'hFF0F, 16'hA505, 16'h3C0C, 16'h0000,
                                      16'h0606, 16'h9B0B};

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] d, input logic tk = 0);
    @(negedge clk); cs = 1; we = 0; addr = a; cascade_tick = tk;
    #2 d = rdata;
    @(negedge clk); cs = 0; cascade_tick = 0;
  endtask

  task automatic ld(logic s, logic [9:0] v);
    @(negedge clk); cmp_we = 1; cmp_sel = s; cmp_val = v;
    @(negedge clk); cmp_we = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] d;
    logic [9:0] c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 count", cnt_out, 0);
    chk("R1 irq", irq, 0);
    rd(0, d); chk("R1 status", d, 0);
    rd(1, d); chk("R1 control", d, 0);

    for (int i = 0; i < 6; i++) begin
      wr(1, CRV[i][15:8]);
      rd(1, d);
      chk("R9 control readback", d, CRV[i][7:0]);
      chk("R11 irq_pri", irq_pri, CRV[i][1:0]);
    end

    wr(1, 8'h00);
    ld(0, 10'd5); ld(1, 10'd9);
    wr(0, 8'h07);
    c0 = cnt_out; idle(20);
    chk("R6 base rate", cnt_out - c0, 10);
    idle(10);
    chk("R11 pri0 blocks irq", irq, 0);
    wr(1, 8'h01);
    chk("R11 irq raised", irq, 1);
    chk("R11 irq_pri", irq_pri, 1);
    rd(0, d); chk("R2 R10 flags set", d, 8'h07);
    rd(0, d); chk("R3 flags cleared", d, 8'h01);
    chk("R3 irq cleared", irq, 0);

    wr(0, 8'h06);
    c0 = cnt_out; idle(20);
    chk("R5 stopped holds", cnt_out, c0);
    rd(0, d); chk("R2 run bit low", d, 8'h00);

    wr(1, 8'h05); wr(0, 8'h07);
    c0 = cnt_out; idle(10);
    chk("R8 no tick no count", cnt_out, c0);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); cascade_tick = 1;
      @(negedge clk); cascade_tick = 0;
      @(negedge clk);
    end
    chk("R8 cascade count", cnt_out - c0, 7);

    wr(1, 8'h09);
    c0 = cnt_out; idle(160);
    chk("R7 slow rate", cnt_out - c0, 10);
    wr(1, 8'h0D);
    c0 = cnt_out; idle(64);
    chk("R7 slow rate 11", cnt_out - c0, 4);

    wr(1, 8'h05);
    c0 = cnt_out;
    ld(0, c0); ld(1, c0 + 10'd100);
    rd(0, d);
    rd(0, d, 1'b1); chk("R4 read value before match", d, 8'h01);
    chk("R12 R8 counted", cnt_out, c0 + 10'd1);
    rd(0, d); chk("R4 flag survives read", d, 8'h03);

    wr(1, 8'h01);
    ld(0, 10'd1023); ld(1, 10'd0);
    wr(0, 8'h03);
    rd(0, d);
    chk("R3 irq low before wrap", irq, 0);
    for (int k = 0; k < 4000 && cnt_out != 10'd1023; k++) @(negedge clk);
    chk("R10 reached top", cnt_out, 1023);
    idle(2);
    chk("R10 wrap to zero", cnt_out, 0);
    chk("R3 enable kept irq", irq, 1);
    idle(4);
    rd(0, d); chk("R10 both channels matched", d, 8'h07);
    chk("R11 irq after clear", irq, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule